// File: doc/BRIEF.md
# Trace Unit Control Register

This block is the main configuration register of an on-chip trace unit. It sits on a simple register bus with an address, a write strobe, write data and combinational read data. It holds the trace configuration fields: core selection, port width and clocking mode, context identifier width, data tracing mode, branch and cycle options, and the programming and power-down flags. From those fields it drives the trace power-up output and the trace port enable output.

The block also gates writes to the neighbouring registers of the trace unit. While the power-down flag is set, only this register and a lock register may be written. When its arm bit is set, a trigger event raises a debug request that stays high until the debugger acknowledges it. Two status flags report when the stored port width or port mode is not the single supported encoding, so that a configuration register elsewhere can show them.

Top module: `trc_ctrl_reg`

## Requirements
- R1: Bits [31:28], [24:22] and [7] always read as 0, and any value written to them is discarded.
- R2: After reset the register reads 0x0000_0441: power-down (bit 0) = 1, programming (bit 10) = 1, port size low field [6:4] = 3'b100, and all other fields 0.
- R3: `pwr_up` is the inverse of stored bit 0.
- R4: `port_en` equals stored bit 11.
- R5: If arm bit 9 is 1 when `trig` is sampled high, `dbg_req` is high from the next cycle onward. It stays high until `dbg_ack` is sampled high and falls on the cycle after. A trigger with bit 9 at 0, or a trigger while the request is pending, has no effect.
- R6: Port size {bit 21, bits [6:4]} and port mode {bit 13, bits [17:16]} read back as written. `psize_bad` is high when the size differs from 4'b0100, and `pmode_bad` is high when the mode differs from 3'b000.
- R7: `ctx_bytes` decodes field [15:14]: 00 gives 0, 01 gives 1, 10 gives 2, 11 gives 4.
- R8: Field [3:2] drives {`daddr_en`,`ddata_en`}: 00 gives 00, 01 gives 01 (data only), 10 gives 10 (address only), 11 gives 11.
- R9: Core select [27:25] never holds a value above MAX_CORE (default 3). A larger written value is stored as MAX_CORE.
- R10: `nbr_we` is high only for a write to an address other than CTRL_ADDR (default 0). The address must also be LOCK_ADDR (default 0x3EC), or stored bit 0 must be 0.
- R11: A write to CTRL_ADDR takes effect at the clock edge where `bus_we` is high, even while powered down. `bus_rdata` is 0 for any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the control register, 0 otherwise |
| trig | input | 1 | Trigger event |
| dbg_ack | input | 1 | Debug acknowledge |
| dbg_req | output | 1 | Debug request |
| pwr_up | output | 1 | Trace power-up |
| port_en | output | 1 | Trace port enable |
| nbr_we | output | 1 | Write strobe permitted to neighbour registers |
| psize_bad | output | 1 | Unsupported port size stored |
| pmode_bad | output | 1 | Unsupported port mode stored |
| core_sel | output | 3 | Selected core |
| ctx_bytes | output | 3 | Context identifier bytes traced |
| daddr_en | output | 1 | Data address tracing enabled |
| ddata_en | output | 1 | Data value tracing enabled |

## Verification
A corrupted stored field shows at the ports in the cycle after the write that set it. The read data, `pwr_up`, `port_en`, the decoded outputs and the two unsupported flags all follow the stored value combinationally. A stuck or mistimed debug handshake shows as `dbg_req` holding high past the cycle after the acknowledge, or rising without an armed trigger. Wrong gating shows as `nbr_we` high during a powered-down write to a neighbour address, which is visible in the same cycle.

// File: rtl/trc_ctrl_pkg.sv
package trc_ctrl_pkg;

    typedef struct packed {
        logic [3:0] rsvd;
        logic [2:0] core_sel;
        logic [2:0] raz_hi;
        logic       psize_hi;
        logic       data_only;
        logic       cprt_filt;
        logic       supp_data;
        logic [1:0] pmode_lo;
        logic [1:0] ctx_sz;
        logic       pmode_hi;
        logic       cyc_acc;
        logic       port_sel;
        logic       prog;
        logic       dbg_arm;
        logic       br_all;
        logic       raz_stall;
        logic [2:0] psize_lo;
        logic [1:0] dacc;
        logic       cprt_mon;
        logic       pdown;
    } ctrl_t;

    typedef enum logic [1:0] {
        DACC_NONE = 2'b00,
        DACC_DATA = 2'b01,
        DACC_ADDR = 2'b10,
        DACC_BOTH = 2'b11
    } dacc_e;

    localparam logic [31:0] WR_MASK  = 32'h0E3F_FF7F;
    localparam logic [31:0] RST_WORD = 32'h0000_0441;
    localparam logic [3:0]  PSIZE_OK = 4'b0100;
    localparam logic [2:0]  PMODE_OK = 3'b000;

    function automatic ctrl_t clean_word(input logic [31:0] w, input logic [2:0] lim);
        ctrl_t c;
        c = ctrl_t'(w & WR_MASK);
        if (c.core_sel > lim) c.core_sel = lim;
        return c;
    endfunction

    function automatic logic [2:0] ctx_count(input logic [1:0] sz);
        case (sz)
            2'b00:   return 3'd0;
            2'b01:   return 3'd1;
            2'b10:   return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [3:0] psize_of(input ctrl_t c);
        return {c.psize_hi, c.psize_lo};
    endfunction

    function automatic logic [2:0] pmode_of(input ctrl_t c);
        return {c.pmode_hi, c.pmode_lo};
    endfunction

endpackage

// File: rtl/trc_ctrl_store.sv
module trc_ctrl_store
    import trc_ctrl_pkg::*;
#(
    parameter logic [2:0] CORE_LIM = 3'd3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output ctrl_t       q
);
    always_ff @(posedge clk) begin
        if (rst)        q <= ctrl_t'(RST_WORD);
        else if (wr_en) q <= clean_word(wdata, CORE_LIM);
    end
endmodule

// File: rtl/trc_ctrl_decode.sv
module trc_ctrl_decode #(
    parameter int ADDR_W = 10,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
    parameter logic [ADDR_W-1:0] LOCK_ADDR = '1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              pdown,
    output logic              hit_ctrl,
    output logic              ctrl_we,
    output logic              nbr_we
);
    logic hit_lock;

    always_comb begin
        hit_ctrl = (addr == CTRL_ADDR);
        hit_lock = (addr == LOCK_ADDR);
        ctrl_we  = we && hit_ctrl;
        nbr_we   = we && !hit_ctrl && (hit_lock || !pdown);
    end
endmodule

// File: rtl/trc_dbg_hs.sv
module trc_dbg_hs (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic trig,
    input  logic ack,
    output logic req
);
    typedef enum logic {HS_IDLE, HS_WAIT} hs_e;
    hs_e st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= HS_IDLE;
        end else begin
            case (st)
                HS_IDLE: if (arm && trig) st <= HS_WAIT;
                HS_WAIT: if (ack)         st <= HS_IDLE;
                default:                  st <= HS_IDLE;
            endcase
        end
    end

    assign req = (st == HS_WAIT);
endmodule

// File: rtl/trc_ctrl_reg.sv
module trc_ctrl_reg
    import trc_ctrl_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int MAX_CORE = 3,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
    parameter logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'('h3EC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              trig,
    input  logic              dbg_ack,
    output logic              dbg_req,
    output logic              pwr_up,
    output logic              port_en,
    output logic              nbr_we,
    output logic              psize_bad,
    output logic              pmode_bad,
    output logic [2:0]        core_sel,
    output logic [2:0]        ctx_bytes,
    output logic              daddr_en,
    output logic              ddata_en
);
    localparam logic [2:0] CORE_LIM = 3'(MAX_CORE);

    ctrl_t cfg;
    logic  hit_ctrl;
    logic  ctrl_we;
    dacc_e dmode;

    trc_ctrl_decode #(
        .ADDR_W   (ADDR_W),
        .CTRL_ADDR(CTRL_ADDR),
        .LOCK_ADDR(LOCK_ADDR)
    ) u_dec (
        .addr    (bus_addr),
        .we      (bus_we),
        .pdown   (cfg.pdown),
        .hit_ctrl(hit_ctrl),
        .ctrl_we (ctrl_we),
        .nbr_we  (nbr_we)
    );

    trc_ctrl_store #(.CORE_LIM(CORE_LIM)) u_store (
        .clk  (clk),
        .rst  (rst),
        .wr_en(ctrl_we),
        .wdata(bus_wdata),
        .q    (cfg)
    );

    trc_dbg_hs u_hs (
        .clk (clk),
        .rst (rst),
        .arm (cfg.dbg_arm),
        .trig(trig),
        .ack (dbg_ack),
        .req (dbg_req)
    );

    always_comb begin
        bus_rdata = hit_ctrl ? 32'(cfg) : 32'h0;
        pwr_up    = !cfg.pdown;
        port_en   = cfg.port_sel;
        psize_bad = (psize_of(cfg) != PSIZE_OK);
        pmode_bad = (pmode_of(cfg) != PMODE_OK);
        core_sel  = cfg.core_sel;
        ctx_bytes = ctx_count(cfg.ctx_sz);
        dmode     = dacc_e'(cfg.dacc);
        daddr_en  = (dmode == DACC_ADDR) || (dmode == DACC_BOTH);
        ddata_en  = (dmode == DACC_DATA) || (dmode == DACC_BOTH);
    end
endmodule

// File: rtl/trc_ctrl_chk.sv
module trc_ctrl_chk #(
    parameter int ADDR_W = 10,
    parameter int MAX_CORE = 3,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
    parameter logic [ADDR_W-1:0] LOCK_ADDR = '1
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              trig,
    input logic              dbg_ack,
    input logic              dbg_req,
    input logic              pwr_up,
    input logic              port_en,
    input logic              nbr_we
);
    // R1
    raz_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == CTRL_ADDR) |-> (bus_rdata[31:28] == 4'h0 && bus_rdata[24:22] == 3'h0 && !bus_rdata[7]));

    // R2
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pwr_up && !port_en && !dbg_req));

    // R3
    pwr_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == CTRL_ADDR) |=> (pwr_up == !$past(bus_wdata[0])));

    // R4
    port_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == CTRL_ADDR) |=> (port_en == $past(bus_wdata[11])));

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dbg_req && !dbg_ack) |=> dbg_req);

    // R5
    req_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (dbg_req && dbg_ack) |=> !dbg_req);

    // R5
    req_no_trig_chk: assert property (@(posedge clk) disable iff (rst)
        (!dbg_req && !trig) |=> !dbg_req);

    // R9
    core_lim_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == CTRL_ADDR) |-> (int'(bus_rdata[27:25]) <= MAX_CORE));

    // R10
    nbr_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!pwr_up && bus_addr != LOCK_ADDR) |-> !nbr_we);

    // R10
    nbr_self_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == CTRL_ADDR) |-> !nbr_we);
endmodule

bind trc_ctrl_reg trc_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .MAX_CORE (MAX_CORE),
    .CTRL_ADDR(CTRL_ADDR),
    .LOCK_ADDR(LOCK_ADDR)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .trig     (trig),
    .dbg_ack  (dbg_ack),
    .dbg_req  (dbg_req),
    .pwr_up   (pwr_up),
    .port_en  (port_en),
    .nbr_we   (nbr_we)
);

// File: tb/trc_ctrl_reg_test.sv
`timescale 1ns/1ps
module trc_ctrl_reg_test;
    localparam int AW = 10;
    localparam logic [AW-1:0] A_CTRL = 10'h000;
    localparam logic [AW-1:0] A_LOCK = 10'h3EC;
    localparam logic [AW-1:0] A_NBR  = 10'h004;

    localparam int S_RD = 0, S_PWR = 1, S_PEN = 2, S_REQ = 3, S_NBR = 4,
                   S_PSB = 5, S_PMB = 6, S_CORE = 7, S_CTX = 8, S_DACC = 9;

    logic          clk = 0;
    logic          rst = 1;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          trig = 0, dbg_ack = 0;
    logic          dbg_req, pwr_up, port_en, nbr_we, psize_bad, pmode_bad;
    logic [2:0]    core_sel, ctx_bytes;
    logic          daddr_en, ddata_en;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        string       tag;
        int          sig;
        logic [31:0] exp;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    trc_ctrl_reg uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig(trig),
        .dbg_ack(dbg_ack), .dbg_req(dbg_req), .pwr_up(pwr_up),
        .port_en(port_en), .nbr_we(nbr_we), .psize_bad(psize_bad),
        .pmode_bad(pmode_bad), .core_sel(core_sel), .ctx_bytes(ctx_bytes),
        .daddr_en(daddr_en), .ddata_en(ddata_en)
    );

    function automatic logic [31:0] observe(int sig);
        case (sig)
            S_RD:    return bus_rdata;
            S_PWR:   return {31'b0, pwr_up};
            S_PEN:   return {31'b0, port_en};
            S_REQ:   return {31'b0, dbg_req};
            S_NBR:   return {31'b0, nbr_we};
            S_PSB:   return {31'b0, psize_bad};
            S_PMB:   return {31'b0, pmode_bad};
            S_CORE:  return {29'b0, core_sel};
            S_CTX:   return {29'b0, ctx_bytes};
            default: return {30'b0, daddr_en, ddata_en};
        endcase
    endfunction

    // monitor: pops expected items and compares against the ports
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [31:0] got;
            it = sb.pop_front();
            got = observe(it.sig);
            total++;
            if (got !== it.exp) begin
                bad++;
                $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
            end
        end
    end

    task automatic expect_now(string tag, int sig, logic [31:0] exp);
        sb.push_back('{tag, sig, exp});
    endtask

    task automatic settle;
        @(negedge clk); #1;
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_we = 1; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 0; bus_addr = A_CTRL;
    endtask

    task automatic pulse_trig;
        @(posedge clk); #1 trig = 1;
        @(posedge clk); #1 trig = 0;
    endtask

    task automatic probe_nbr(string tag, logic [AW-1:0] a, logic exp);
        @(posedge clk); #1;
        bus_addr = a; bus_we = 1; bus_wdata = 32'h0;
        expect_now(tag, S_NBR, {31'b0, exp});
        settle();
        bus_we = 0; bus_addr = A_CTRL;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        settle();

        // R2 reset state
        expect_now("R2 reset word", S_RD, 32'h0000_0441);
        expect_now("R2 R3 pwr_up after reset", S_PWR, 0);
        expect_now("R2 R4 port_en after reset", S_PEN, 0);
        expect_now("R2 R5 dbg_req after reset", S_REQ, 0);
        expect_now("R2 R6 psize_bad after reset", S_PSB, 0);
        expect_now("R2 R6 pmode_bad after reset", S_PMB, 0);
        settle();

        // R11 other address reads zero
        bus_addr = A_NBR;
        expect_now("R11 rdata other addr", S_RD, 0);
        settle();

        // R10 gating while powered down
        probe_nbr("R10 nbr write powered down", A_NBR, 0);
        probe_nbr("R10 lock write powered down", A_LOCK, 1);
        probe_nbr("R10 ctrl addr never nbr", A_CTRL, 0);

        // R1 R9 R11 all-ones write while powered down
        wr(A_CTRL, 32'hFFFF_FFFF);
        expect_now("R1 R9 R11 all-ones readback", S_RD, 32'h063F_FF7F);
        expect_now("R9 core clamp", S_CORE, 3);
        expect_now("R3 pwr_up low", S_PWR, 0);
        expect_now("R4 port_en high", S_PEN, 1);
        expect_now("R6 psize_bad", S_PSB, 1);
        expect_now("R6 pmode_bad", S_PMB, 1);
        expect_now("R7 ctx 11", S_CTX, 4);
        expect_now("R8 dacc 11", S_DACC, 3);
        settle();

        // R3 power up
        wr(A_CTRL, 32'h0000_0840);
        expect_now("R11 readback 840", S_RD, 32'h0000_0840);
        expect_now("R3 pwr_up high", S_PWR, 1);
        expect_now("R6 supported size", S_PSB, 0);
        expect_now("R6 supported mode", S_PMB, 0);
        expect_now("R7 ctx 00", S_CTX, 0);
        expect_now("R8 dacc 00", S_DACC, 0);
        settle();
        probe_nbr("R10 nbr write powered up", A_NBR, 1);

        // R4 port enable low
        wr(A_CTRL, 32'h0000_0040);
        expect_now("R4 port_en low", S_PEN, 0);
        settle();

        // R7 R8 decodes
        wr(A_CTRL, 32'h0000_8844);
        expect_now("R7 ctx 10", S_CTX, 2);
        expect_now("R8 dacc 01 data only", S_DACC, 1);
        settle();
        wr(A_CTRL, 32'h0000_4848);
        expect_now("R7 ctx 01", S_CTX, 1);
        expect_now("R8 dacc 10 addr only", S_DACC, 2);
        settle();

        // R6 each field alone
        wr(A_CTRL, 32'h0020_0840);
        expect_now("R6 size bit readback", S_RD, 32'h0020_0840);
        expect_now("R6 size bit bad", S_PSB, 1);
        expect_now("R6 mode ok", S_PMB, 0);
        settle();
        wr(A_CTRL, 32'h0000_2840);
        expect_now("R6 mode bit readback", S_RD, 32'h0000_2840);
        expect_now("R6 mode bit bad", S_PMB, 1);
        expect_now("R6 size ok", S_PSB, 0);
        settle();

        // R9 in-range core
        wr(A_CTRL, 32'h0400_0840);
        expect_now("R9 core 2", S_CORE, 2);
        settle();

        // R1 raz bits alone
        wr(A_CTRL, 32'hF1C0_0080);
        expect_now("R1 raz discarded", S_RD, 0);
        settle();

        // R5 unarmed trigger ignored
        wr(A_CTRL, 32'h0000_0840);
        pulse_trig();
        expect_now("R5 unarmed trigger", S_REQ, 0);
        settle();

        // R5 armed handshake
        wr(A_CTRL, 32'h0000_0A40);
        pulse_trig();
        expect_now("R5 request raised", S_REQ, 1);
        settle();
        repeat (3) @(posedge clk);
        #1 expect_now("R5 request held", S_REQ, 1);
        settle();
        pulse_trig();
        expect_now("R5 retrigger no effect", S_REQ, 1);
        settle();
        @(posedge clk); #1 dbg_ack = 1;
        expect_now("R5 ack not yet sampled", S_REQ, 1);
        settle();
        @(posedge clk); #1 dbg_ack = 0;
        expect_now("R5 request cleared", S_REQ, 0);
        settle();
        @(posedge clk); #1 dbg_ack = 1;
        @(posedge clk); #1 dbg_ack = 0;
        expect_now("R5 ack idle no effect", S_REQ, 0);
        settle();

        settle();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule